// File: doc/BRIEF.md
# Vector Element Byte Load/Store Unit

This unit carries out the short vector memory transfers of a vector coprocessor. It moves 1, 2, 4 or 8 consecutive bytes between a 4 KB byte-addressed data memory and one 128-bit vector register. A single start pulse hands it a 32-bit instruction word, a direction flag and a size code. In that same cycle it reads the base value through a scalar register file port. It then forms the effective address and latches everything it needs.

From the next cycle it moves one byte per clock. Stores are driven onto a byte-wide memory write port. Loads are driven onto a byte-lane write-enable port of the vector register file. The unit raises a one-cycle done flag when the last byte has gone.

Memory holds big-endian words in little-endian storage, so every byte address is swizzled before it leaves the unit. The 12-bit address wraps at each byte. Stores wrap their source byte inside the register. Loads drop any byte whose destination lane would fall past the end of the register.

Top module: `vec_bytemove_unit`

## Requirements
- R1: The instruction word is decoded as follows. Bits 25:21 select the base scalar register, shown on `sreg_idx_o` while `start_i` is high. Bits 20:16 select the vector register, shown on `vreg_idx_o` during the transfer. Bits 10:7 give the starting element (0..15). Bits 6:0 give a two's-complement offset with bit 6 as its sign.
- R2: `size_i` gives the transfer length: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. `is_store_i` = 1 selects the memory-write direction and 0 selects the register-write direction.
- R3: The first logical byte address is (base + length × signed offset) modulo 4096.
- R4: Byte i of a transfer uses logical address (first + i) modulo 4096, so a transfer that runs past 0xFFF continues at 0x000.
- R5: `mem_addr_o` carries the logical byte address with its two low bits inverted (XOR 3).
- R6: On a store, byte i is taken from register lane (element + i) mod 16. Lane k occupies bits 8k+7:8k of the 128-bit register.
- R7: On a load, byte i is written to lane element + i. If that lane is 16 or more, no write enable is raised and the register is left unchanged.
- R8: When the base field is 0, the base is taken as zero whatever `sreg_data_i` carries.
- R9: One byte moves per clock, starting the cycle after the start edge. `done_o` is high for exactly one cycle, and is first seen `length` clock edges after the start edge.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The running transfer completes unchanged and no second transfer follows.
- R11: After reset, `busy_o`, `done_o`, `mem_we_o` and `vreg_we_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer (ignored while busy) |
| instr_i | input | 32 | Instruction word, sampled with start |
| is_store_i | input | 1 | 1 = register to memory, 0 = memory to register |
| size_i | input | 2 | Transfer length code |
| sreg_idx_o | output | 5 | Scalar register read index |
| sreg_data_i | input | 32 | Scalar register read data (same cycle) |
| mem_addr_o | output | 12 | Swizzled data memory byte address |
| mem_rdata_i | input | 8 | Memory read byte (combinational) |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_we_o | output | 1 | Memory byte write enable |
| vreg_idx_o | output | 5 | Vector register index |
| vreg_rdata_i | input | 128 | Vector register read data (combinational) |
| vreg_wdata_o | output | 128 | Vector register write data (byte replicated) |
| vreg_be_o | output | 16 | Vector register byte-lane enables |
| vreg_we_o | output | 1 | Vector register write strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion flag |

## Verification
A transfer of length L writes its bytes on the L clock edges after the start edge. `done_o` is visible between edge L and edge L+1. The bench drives every input just after a falling edge and counts falling edges from the start pulse until it sees done. It expects exactly L+1 of them, and only then compares the whole memory image and all 32 vector registers against its own model. For the ignored-start case it also waits several cycles past done and checks that no second done or write appears.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned VBYTES  = 16;
  localparam int unsigned MAX_LEN = 8;

  typedef enum logic [1:0] {
    SZ_BYTE   = 2'd0,
    SZ_HALF   = 2'd1,
    SZ_WORD   = 2'd2,
    SZ_DOUBLE = 2'd3
  } vbm_size_e;

  // transfer length in bytes from the size code
  function automatic logic [3:0] vbm_len(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // first logical address: base + len * signed offset, kept to 12 bits
  function automatic logic [ADDR_W-1:0] vbm_first_addr(input logic [31:0] base,
                                                       input logic [1:0] sz,
                                                       input logic [6:0] off);
    logic [31:0] scaled;
    logic [31:0] sum;
    scaled = {{25{off[6]}}, off} << sz;
    sum    = base + scaled;
    return sum[ADDR_W-1:0];
  endfunction

  // big-endian word in little-endian storage
  function automatic logic [ADDR_W-1:0] vbm_swizzle(input logic [ADDR_W-1:0] a);
    return a ^ ADDR_W'(3);
  endfunction
endpackage

// File: rtl/vbm_decode.sv
module vbm_decode
  import vbm_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned ELEM_W = 4
) (
  input  logic [31:0]       instr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       sreg_data_i,
  output logic [REG_W-1:0]  base_idx_o,
  output logic [REG_W-1:0]  vreg_idx_o,
  output logic [ELEM_W-1:0] elem_o,
  output logic [3:0]        len_o,
  output logic [ADDR_W-1:0] first_addr_o
);
  logic [31:0] base_val;
  logic [6:0]  off;

  assign base_idx_o = instr_i[25:21];
  assign vreg_idx_o = instr_i[20:16];
  assign elem_o     = instr_i[10:7];
  assign off        = instr_i[6:0];
  assign len_o      = vbm_len(size_i);

  // register zero is hard-wired to zero (R8)
  assign base_val     = (base_idx_o == '0) ? 32'd0 : sreg_data_i;
  assign first_addr_o = vbm_first_addr(base_val, size_i, off);
endmodule

// File: rtl/vbm_seq.sv
module vbm_seq
  import vbm_pkg::*;
#(
  parameter int unsigned CNT_W = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [3:0]       len_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             done_o
);
  logic [3:0] len_q;

  assign accept_o = start_i && !busy_o;
  assign last_o   = busy_o && ({1'b0, cnt_o} == (len_q - 4'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
      len_q  <= 4'd1;
      done_o <= 1'b0;
    end else begin
      done_o <= last_o;
      if (accept_o) begin
        busy_o <= 1'b1;
        cnt_o  <= '0;
        len_q  <= len_i;
      end else if (busy_o) begin
        if (last_o) busy_o <= 1'b0;
        else        cnt_o  <= cnt_o + 1'b1;
      end
    end
  end

  // R9: done is a single-cycle pulse, never during a transfer
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R10: a start while busy does not restart the count
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !last_o) |=> (busy_o && cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/vbm_lane.sv
module vbm_lane
  import vbm_pkg::*;
#(
  parameter int unsigned CNT_W = $clog2(MAX_LEN),
  parameter int unsigned ELEM_W = $clog2(VBYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy_i,
  input  logic                is_store_i,
  input  logic [ELEM_W-1:0]   elem_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [ADDR_W-1:0]   first_addr_i,
  input  logic [VBYTES*8-1:0] vreg_rdata_i,
  input  logic [7:0]          mem_rdata_i,
  output logic [ADDR_W-1:0]   log_addr_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [7:0]          mem_wdata_o,
  output logic                mem_we_o,
  output logic [VBYTES*8-1:0] vreg_wdata_o,
  output logic [VBYTES-1:0]   vreg_be_o,
  output logic                vreg_we_o
);
  localparam int unsigned LANE_W = ELEM_W + 1;

  logic [LANE_W-1:0] ld_lane;
  logic [ELEM_W-1:0] st_lane;
  logic              ld_in_range;

  // per-byte address, wraps at 4 KB (R4), swizzled (R5)
  assign log_addr_o = first_addr_i + ADDR_W'(cnt_i);
  assign mem_addr_o = vbm_swizzle(log_addr_o);

  // store source lane wraps inside the register (R6)
  assign st_lane     = elem_i + ELEM_W'(cnt_i);
  assign mem_wdata_o = vreg_rdata_i[st_lane*8 +: 8];
  assign mem_we_o    = busy_i && is_store_i;

  // load destination lane does not wrap; overflow is dropped (R7)
  assign ld_lane     = LANE_W'(elem_i) + LANE_W'(cnt_i);
  assign ld_in_range = !ld_lane[ELEM_W];
  assign vreg_we_o   = busy_i && !is_store_i && ld_in_range;
  assign vreg_wdata_o = {VBYTES{mem_rdata_i}};

  always_comb begin
    vreg_be_o = '0;
    if (vreg_we_o) vreg_be_o[ld_lane[ELEM_W-1:0]] = 1'b1;
  end

  // R7: a register write touches exactly one lane
  p_one_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_we_o |-> $onehot(vreg_be_o));
  p_no_stray_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vreg_we_o |-> (vreg_be_o == '0));
  // R2: the two write ports are never active together
  p_dir_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && vreg_we_o));
endmodule

// File: rtl/vec_bytemove_unit.sv
module vec_bytemove_unit
  import vbm_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned ELEM_W = $clog2(VBYTES),
  parameter int unsigned CNT_W  = $clog2(MAX_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [31:0]         instr_i,
  input  logic                is_store_i,
  input  logic [1:0]          size_i,
  output logic [REG_W-1:0]    sreg_idx_o,
  input  logic [31:0]         sreg_data_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic [7:0]          mem_rdata_i,
  output logic [7:0]          mem_wdata_o,
  output logic                mem_we_o,
  output logic [REG_W-1:0]    vreg_idx_o,
  input  logic [VBYTES*8-1:0] vreg_rdata_i,
  output logic [VBYTES*8-1:0] vreg_wdata_o,
  output logic [VBYTES-1:0]   vreg_be_o,
  output logic                vreg_we_o,
  output logic                busy_o,
  output logic                done_o
);
  logic [REG_W-1:0]  dec_vreg;
  logic [ELEM_W-1:0] dec_elem;
  logic [3:0]        dec_len;
  logic [ADDR_W-1:0] dec_addr;

  logic              accept;
  logic [CNT_W-1:0]  cnt;
  logic              last;
  logic [ADDR_W-1:0] log_addr;

  logic              store_q;
  logic [ELEM_W-1:0] elem_q;
  logic [REG_W-1:0]  vreg_q;
  logic [ADDR_W-1:0] addr_q;

  vbm_decode #(.REG_W(REG_W), .ELEM_W(ELEM_W)) u_decode (
    .instr_i      (instr_i),
    .size_i       (size_i),
    .sreg_data_i  (sreg_data_i),
    .base_idx_o   (sreg_idx_o),
    .vreg_idx_o   (dec_vreg),
    .elem_o       (dec_elem),
    .len_o        (dec_len),
    .first_addr_o (dec_addr)
  );

  vbm_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .len_i    (dec_len),
    .accept_o (accept),
    .busy_o   (busy_o),
    .cnt_o    (cnt),
    .last_o   (last),
    .done_o   (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= 1'b0;
      elem_q  <= '0;
      vreg_q  <= '0;
      addr_q  <= '0;
    end else if (accept) begin
      store_q <= is_store_i;
      elem_q  <= dec_elem;
      vreg_q  <= dec_vreg;
      addr_q  <= dec_addr;
    end
  end

  assign vreg_idx_o = vreg_q;

  vbm_lane #(.CNT_W(CNT_W), .ELEM_W(ELEM_W)) u_lane (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_o),
    .is_store_i   (store_q),
    .elem_i       (elem_q),
    .cnt_i        (cnt),
    .first_addr_i (addr_q),
    .vreg_rdata_i (vreg_rdata_i),
    .mem_rdata_i  (mem_rdata_i),
    .log_addr_o   (log_addr),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_we_o     (mem_we_o),
    .vreg_wdata_o (vreg_wdata_o),
    .vreg_be_o    (vreg_be_o),
    .vreg_we_o    (vreg_we_o)
  );

  // R4: consecutive bytes step the logical address by one, wrapping at 4 KB
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last) |=> (log_addr == $past(log_addr) + 1'b1));
  // R10: latched transfer state holds while a start arrives mid-transfer
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(addr_q) && $stable(elem_q) && $stable(store_q)));
  // R8: base field zero yields the scaled offset alone
  p_base_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sreg_idx_o == '0) |=>
      (addr_q == vbm_first_addr(32'd0, $past(size_i), $past(instr_i[6:0]))));
  // R9: a write strobe is only ever raised during a transfer
  p_we_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o || vreg_we_o) |-> busy_o);
endmodule

// File: tb/test_vec_bytemove_unit.sv
module test_vec_bytemove_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  instr = '0;
  logic         is_store = 1'b0;
  logic [1:0]   size = '0;
  logic [4:0]   sreg_idx;
  logic [31:0]  sreg_data;
  logic [11:0]  mem_addr;
  logic [7:0]   mem_rdata, mem_wdata;
  logic         mem_we;
  logic [4:0]   vreg_idx;
  logic [127:0] vreg_rdata, vreg_wdata;
  logic [15:0]  vreg_be;
  logic         vreg_we, busy, done;

  logic [7:0]   mem   [4096];
  logic [127:0] vr    [32];
  logic [31:0]  sr    [32];
  logic [7:0]   e_mem [4096];
  logic [127:0] e_vr  [32];

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sreg_data  = sr[sreg_idx];
  assign mem_rdata  = mem[mem_addr];
  assign vreg_rdata = vr[vreg_idx];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (vreg_we)
      for (int k = 0; k < 16; k++)
        if (vreg_be[k]) vr[vreg_idx][k*8 +: 8] <= vreg_wdata[k*8 +: 8];
  end

  vec_bytemove_unit i_vec_bytemove_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start), .instr_i(instr),
    .is_store_i(is_store), .size_i(size),
    .sreg_idx_o(sreg_idx), .sreg_data_i(sreg_data),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .vreg_idx_o(vreg_idx), .vreg_rdata_i(vreg_rdata),
    .vreg_wdata_o(vreg_wdata), .vreg_be_o(vreg_be), .vreg_we_o(vreg_we),
    .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(input int base, input int vt,
                                           input int elem, input int off);
    logic [31:0] w;
    w = '0;
    w[25:21] = 5'(base);
    w[20:16] = 5'(vt);
    w[10:7]  = 4'(elem);
    w[6:0]   = 7'(off);
    w[15:11] = 5'b10101;   // unused field, must not matter
    return w;
  endfunction

  // Expected-state model written from the requirements
  task automatic model_op(input bit st, input int sz, input int base, input int vt,
                          input int elem, input int off);
    int len, b, first, la, pa, lane;
    len   = 1 << sz;                                   // R2
    b     = (base == 0) ? 0 : int'(sr[base]);          // R8
    first = (b + len * off) & 12'hFFF;                 // R3
    for (int i = 0; i < len; i++) begin
      la = (first + i) % 4096;                         // R4
      pa = la ^ 3;                                     // R5
      if (st) begin
        lane = (elem + i) % 16;                        // R6
        e_mem[pa] = e_vr[vt][lane*8 +: 8];
      end else begin
        lane = elem + i;                               // R7
        if (lane < 16) e_vr[vt][lane*8 +: 8] = e_mem[pa];
      end
    end
  endtask

  task automatic compare_state(input string req);
    int bad = 0, first_i = -1;
    for (int i = 0; i < 4096; i++)
      if (mem[i] !== e_mem[i]) begin bad++; if (first_i < 0) first_i = i; end
    check(bad == 0, req, $sformatf("memory byte 0x%0h", first_i < 0 ? 0 : first_i),
          first_i < 0 ? 0 : longint'(mem[first_i]),
          first_i < 0 ? 0 : longint'(e_mem[first_i]));
    bad = 0; first_i = -1;
    for (int r = 0; r < 32; r++)
      if (vr[r] !== e_vr[r]) begin bad++; if (first_i < 0) first_i = r; end
    check(bad == 0, req, $sformatf("vector reg %0d (low 64 bits)", first_i < 0 ? 0 : first_i),
          first_i < 0 ? 0 : longint'(vr[first_i][63:0]),
          first_i < 0 ? 0 : longint'(e_vr[first_i][63:0]));
  endtask

  // Issue one transfer, measure done timing (R9), then compare state.
  task automatic run_op(input string req, input bit st, input int sz, input int base,
                        input int vt, input int elem, input int off);
    int cyc = 0;
    model_op(st, sz, base, vt, elem, off);
    @(negedge clk);
    instr = mk_instr(base, vt, elem, off); is_store = st; size = 2'(sz); start = 1'b1;
    @(negedge clk);
    start = 1'b0; instr = '0;
    cyc = 1;
    while (!done && cyc < WATCHDOG) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == (1 << sz) + 1, "R9", {req, " done timing"}, cyc, (1 << sz) + 1);
    @(negedge clk);
    check(done == 1'b0, "R9", {req, " done width"}, done, 0);
    compare_state(req);
  endtask

  task automatic t_reset;
    check(busy == 0 && done == 0 && mem_we == 0 && vreg_we == 0, "R11", "reset outputs",
          {busy, done, mem_we, vreg_we}, 0);
  endtask

  task automatic t_base_index;
    @(negedge clk);
    instr = mk_instr(7, 0, 0, 0);
    #1;
    check(sreg_idx == 5'd7, "R1", "base index on sreg_idx_o", sreg_idx, 7);
    instr = '0;
  endtask

  // Start pulse during a running transfer must be ignored
  task automatic t_ignore_start;
    int cyc = 0, extra = 0;
    model_op(1'b0, 3, 2, 9, 2, 1);
    @(negedge clk);
    instr = mk_instr(2, 9, 2, 1); is_store = 1'b0; size = 2'd3; start = 1'b1;
    @(negedge clk);
    instr = mk_instr(1, 3, 0, 0); is_store = 1'b1; size = 2'd3;
    cyc = 1;
    @(negedge clk);
    start = 1'b0; cyc++;
    while (!done && cyc < WATCHDOG) begin @(negedge clk); cyc++; end
    check(cyc == 9, "R10", "ignored start: done timing", cyc, 9);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done || mem_we || vreg_we) extra++;
    end
    check(extra == 0, "R10", "no second transfer", extra, 0);
    compare_state("R10");
  endtask

  initial begin
    bit wd_hit = 0;
    for (int i = 0; i < 4096; i++) begin mem[i] = 8'(i * 7 + 1); e_mem[i] = 8'(i * 7 + 1); end
    for (int r = 0; r < 32; r++) begin
      vr[r] = {4{32'(r * 32'h01030507 + 32'h1111)}};
      e_vr[r] = vr[r];
      sr[r] = 32'(r * 16);
    end
    sr[0] = 32'h55;     // must be ignored as base (R8)
    sr[1] = 32'h100;
    sr[2] = 32'h20;
    sr[5] = 32'hFFC;
    sr[6] = 32'hFFE;
    sr[8] = 32'h7000_0300; // upper bits irrelevant to a 12-bit address

    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_base_index();

    fork
      begin
        run_op("R1 R3 load byte",           1'b0, 0, 1, 4, 3, 2);
        run_op("R6 R3 store word wrap lane", 1'b1, 2, 1, 7, 14, -1);
        run_op("R7 load double drop lanes", 1'b0, 3, 2, 11, 12, 0);
        run_op("R4 R5 store double wrap",   1'b1, 3, 5, 12, 4, 0);
        run_op("R8 load half base zero",    1'b0, 1, 0, 13, 0, 5);
        run_op("R4 load double wrap",       1'b0, 3, 6, 14, 0, 0);
        run_op("R3 store half neg offset",  1'b1, 1, 8, 15, 9, -64);
        t_ignore_start();
      end
      begin
        repeat (5000) @(posedge clk);
        wd_hit = 1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=expired expected=completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule